// File: doc/BRIEF.md
# Single-Bit Complex Lag Correlator

This block cross-correlates two complex baseband streams for one frequency channel and one polarisation. Each sample carries one sign bit for its in-phase part and one for its quadrature part. The samples reach the core as parallel words from an upstream deserialiser, with several samples per clock. Inside a word, lane 0 holds the earliest sample. Stream B passes through a delay line that keeps enough past words to cover every lag, including lags that cross a word boundary. Stream A is multiplied, for each lag, by the conjugate of the delayed B sample.

Every product comes from a small sign-bit lookup, not from an arithmetic multiplier. In each valid clock the lane results of a lag are summed first, and that sum is then added into the lag's real and imaginary accumulators. After a programmed number of valid words the block copies all accumulators into a registered readout bus and clears them in the same cycle, so no word is lost between integrations. It also raises a dump flag for that cycle. Software or a downstream transform then reads the lag spectrum from the readout bus.

Top module: `lagcorr_xf`

## Requirements
- R1: A sign bit of 1 stands for +1 and a bit of 0 stands for -1. Each lane contributes the real part aI*bI + aQ*bQ and the imaginary part aQ*bI - aI*bQ of a·conj(b). Both parts are always even.
- R2: Within a word, lane i holds sample index w*LANES+i, so lane 0 is the earliest. Lag k pairs A sample n with B sample n-k, and this also holds when n-k lies in an earlier word.
- R3: The readout gives lag k in bits [k*ACC_W +: ACC_W] of `dump_re` and `dump_im`, as two's complement values, for k from 0 to NLAGS-1.
- R4: Only words with `in_valid` high are accumulated or shifted into the delay line. A dump follows each `int_len` valid words. An `int_len` of 0 behaves like 1. A cycle with `in_valid` low never yields a dump in the next cycle.
- R5: On a dump, `dump_valid` is high for the cycle after the closing word. The readout holds that integration until the next dump. The next integration starts with the following valid word, and no word is lost.
- R6: A synchronous active-high reset clears the delay line (all bits 0), the accumulators, the word counter, `dump_valid` and the readout. Any partial integration is discarded.
- R7: Accumulators are wide enough for MAX_INT_WORDS words at full-scale correlation without overflow.
- R8: If A is B delayed by d samples, lag d reads real 2*LANES*int_len and imaginary 0. If A is j·B delayed by d, lag d reads real 0 and imaginary 2*LANES*int_len.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A word is present on the sample inputs |
| a_i | input | LANES | Stream A in-phase sign bits, lane 0 earliest |
| a_q | input | LANES | Stream A quadrature sign bits |
| b_i | input | LANES | Stream B in-phase sign bits (delayed stream) |
| b_q | input | LANES | Stream B quadrature sign bits |
| int_len | input | CNT_W | Valid words per integration |
| dump_valid | output | 1 | Readout updated this cycle |
| dump_re | output | NLAGS*ACC_W | Real lag sums, lag k at [k*ACC_W +: ACC_W] |
| dump_im | output | NLAGS*ACC_W | Imaginary lag sums, same layout |

## Verification
On every cycle the assertions check four things: reset silences the dump flag, an idle cycle never produces a dump, the readout stays frozen between dumps, and every dumped lag value is even. Lag alignment across word boundaries, integration length and the zero case, gap tolerance, the correlation peak for delayed and rotated copies, and full-scale accumulation without overflow are shown only by the bench. The bench compares every lag of every dump against a sample-by-sample model.

// File: rtl/lagcorr_pkg.sv
package lagcorr_pkg;

  typedef struct packed {
    logic signed [2:0] re;
    logic signed [2:0] im;
  } cprod_t;

  // Sign-bit lookup: sel = {aI, aQ, bI, bQ}; result = a * conj(b), bit 1 -> +1, bit 0 -> -1
  function automatic cprod_t sign_cmul(input logic [3:0] sel);
    cprod_t r;
    logic ai, aq, bi, bq;
    {ai, aq, bi, bq} = sel;
    r.re = ((ai ~^ bi) ? 3'sd1 : -3'sd1) + ((aq ~^ bq) ? 3'sd1 : -3'sd1);
    r.im = ((aq ~^ bi) ? 3'sd1 : -3'sd1) - ((ai ~^ bq) ? 3'sd1 : -3'sd1);
    return r;
  endfunction

endpackage

// File: rtl/lc_delay_line.sv
module lc_delay_line #(
  parameter int LANES      = 4,
  parameter int HIST_WORDS = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            shift,
  input  logic [LANES-1:0]                b_i,
  input  logic [LANES-1:0]                b_q,
  output logic [LANES*(HIST_WORDS+1)-1:0] tap_i,
  output logic [LANES*(HIST_WORDS+1)-1:0] tap_q
);
  localparam int HB = LANES * HIST_WORDS;
  localparam int TB = LANES * (HIST_WORDS + 1);

  logic [HB-1:0] hist_i, hist_q;

  // Oldest sample at bit 0, current word on top
  assign tap_i = {b_i, hist_i};
  assign tap_q = {b_q, hist_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_i <= '0;
      hist_q <= '0;
    end else if (shift) begin
      hist_i <= tap_i[TB-1:LANES];
      hist_q <= tap_q[TB-1:LANES];
    end
  end
endmodule

// File: rtl/lc_lag_products.sv
module lc_lag_products
  import lagcorr_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int NLAGS      = 8,
  parameter int HIST_WORDS = 2,
  parameter int SUM_W      = 5
) (
  input  logic [LANES-1:0]                a_i,
  input  logic [LANES-1:0]                a_q,
  input  logic [LANES*(HIST_WORDS+1)-1:0] tap_i,
  input  logic [LANES*(HIST_WORDS+1)-1:0] tap_q,
  output logic [NLAGS*SUM_W-1:0]          sum_re,
  output logic [NLAGS*SUM_W-1:0]          sum_im
);
  for (genvar k = 0; k < NLAGS; k++) begin : g_lag
    cprod_t prod [LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam int P = HIST_WORDS * LANES + i - k;
      assign prod[i] = sign_cmul({a_i[i], a_q[i], tap_i[P], tap_q[P]});
    end

    logic signed [SUM_W-1:0] acc_r, acc_i;
    always_comb begin
      acc_r = '0;
      acc_i = '0;
      for (int i = 0; i < LANES; i++) begin
        acc_r = acc_r + SUM_W'(prod[i].re);
        acc_i = acc_i + SUM_W'(prod[i].im);
      end
    end

    assign sum_re[k*SUM_W +: SUM_W] = acc_r;
    assign sum_im[k*SUM_W +: SUM_W] = acc_i;
  end
endmodule

// File: rtl/lc_accum.sv
module lc_accum #(
  parameter int NLAGS = 8,
  parameter int SUM_W = 5,
  parameter int ACC_W = 15,
  parameter int CNT_W = 11
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [CNT_W-1:0]         int_len,
  input  logic [NLAGS*SUM_W-1:0]   sum_re,
  input  logic [NLAGS*SUM_W-1:0]   sum_im,
  output logic                     dump_valid,
  output logic [NLAGS*ACC_W-1:0]   dump_re,
  output logic [NLAGS*ACC_W-1:0]   dump_im
);
  logic [CNT_W-1:0]        cnt;
  logic                    last;
  logic signed [ACC_W-1:0] acc_re [NLAGS];
  logic signed [ACC_W-1:0] acc_im [NLAGS];
  logic signed [ACC_W-1:0] ext_re [NLAGS];
  logic signed [ACC_W-1:0] ext_im [NLAGS];

  // A length of 0 closes on every word, like 1
  assign last = (({1'b0, cnt} + 1'b1) >= {1'b0, int_len});

  for (genvar k = 0; k < NLAGS; k++) begin : g_ext
    assign ext_re[k] = ACC_W'($signed(sum_re[k*SUM_W +: SUM_W]));
    assign ext_im[k] = ACC_W'($signed(sum_im[k*SUM_W +: SUM_W]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      dump_valid <= 1'b0;
      dump_re    <= '0;
      dump_im    <= '0;
      for (int k = 0; k < NLAGS; k++) begin
        acc_re[k] <= '0;
        acc_im[k] <= '0;
      end
    end else begin
      dump_valid <= in_valid && last;
      if (in_valid) begin
        if (last) begin
          cnt <= '0;
          for (int k = 0; k < NLAGS; k++) begin
            dump_re[k*ACC_W +: ACC_W] <= acc_re[k] + ext_re[k];
            dump_im[k*ACC_W +: ACC_W] <= acc_im[k] + ext_im[k];
            acc_re[k] <= '0;
            acc_im[k] <= '0;
          end
        end else begin
          cnt <= cnt + 1'b1;
          for (int k = 0; k < NLAGS; k++) begin
            acc_re[k] <= acc_re[k] + ext_re[k];
            acc_im[k] <= acc_im[k] + ext_im[k];
          end
        end
      end
    end
  end
endmodule

// File: rtl/lagcorr_xf.sv
module lagcorr_xf #(
  parameter int LANES         = 4,
  parameter int NLAGS         = 8,
  parameter int MAX_INT_WORDS = 1024,
  localparam int HIST_WORDS   = (NLAGS - 1 + LANES - 1) / LANES,
  localparam int CNT_W        = $clog2(MAX_INT_WORDS + 1),
  localparam int SUM_W        = $clog2(2 * LANES + 1) + 1,
  localparam int ACC_W        = $clog2(2 * LANES * MAX_INT_WORDS + 1) + 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [LANES-1:0]       a_i,
  input  logic [LANES-1:0]       a_q,
  input  logic [LANES-1:0]       b_i,
  input  logic [LANES-1:0]       b_q,
  input  logic [CNT_W-1:0]       int_len,
  output logic                   dump_valid,
  output logic [NLAGS*ACC_W-1:0] dump_re,
  output logic [NLAGS*ACC_W-1:0] dump_im
);
  localparam int TB = LANES * (HIST_WORDS + 1);

  logic [TB-1:0]          tap_i, tap_q;
  logic [NLAGS*SUM_W-1:0] sum_re, sum_im;

  lc_delay_line #(.LANES(LANES), .HIST_WORDS(HIST_WORDS)) u_dly (
    .clk(clk), .rst(rst), .shift(in_valid),
    .b_i(b_i), .b_q(b_q), .tap_i(tap_i), .tap_q(tap_q)
  );

  lc_lag_products #(.LANES(LANES), .NLAGS(NLAGS), .HIST_WORDS(HIST_WORDS),
                    .SUM_W(SUM_W)) u_prod (
    .a_i(a_i), .a_q(a_q), .tap_i(tap_i), .tap_q(tap_q),
    .sum_re(sum_re), .sum_im(sum_im)
  );

  lc_accum #(.NLAGS(NLAGS), .SUM_W(SUM_W), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_acc (
    .clk(clk), .rst(rst), .in_valid(in_valid), .int_len(int_len),
    .sum_re(sum_re), .sum_im(sum_im),
    .dump_valid(dump_valid), .dump_re(dump_re), .dump_im(dump_im)
  );
endmodule

// File: rtl/lagcorr_xf_chk.sv
module lagcorr_xf_chk #(
  parameter int NLAGS = 8,
  parameter int ACC_W = 15
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   in_valid,
  input logic                   dump_valid,
  input logic [NLAGS*ACC_W-1:0] dump_re,
  input logic [NLAGS*ACC_W-1:0] dump_im
);
  // R6
  rst_quiet_chk: assert property (@(posedge clk) rst |=> !dump_valid);

  // R4
  idle_no_dump_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !dump_valid);

  // R5
  readout_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !dump_valid |-> ($stable(dump_re) && $stable(dump_im)));

  for (genvar k = 0; k < NLAGS; k++) begin : g_par
    // R1
    even_value_chk: assert property (@(posedge clk) disable iff (rst)
      dump_valid |-> (!dump_re[k*ACC_W] && !dump_im[k*ACC_W]));
  end
endmodule

bind lagcorr_xf lagcorr_xf_chk #(.NLAGS(NLAGS), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .dump_valid(dump_valid),
  .dump_re(dump_re), .dump_im(dump_im)
);

// File: tb/tb_lagcorr_xf.sv
module tb_lagcorr_xf;
  localparam int LANES = 4;
  localparam int NLAGS = 8;
  localparam int MAXW  = 1024;
  localparam int CNT_W = $clog2(MAXW + 1);
  localparam int ACC_W = $clog2(2 * LANES * MAXW + 1) + 1;
  localparam int CLK_PERIOD = 8;
  localparam int MAXS = LANES * 1100;

  // mode: 0 delayed copy, 1 delayed j*B, 2 independent, 3 all ones
  typedef struct packed { int mode; int dly; int len; int nd; int gap; int pre; } scen_t;
  localparam int NSCEN = 9;
  localparam scen_t SCEN [NSCEN] = '{
    '{0, 0, 4,    2, 0, 0},
    '{0, 3, 16,   2, 1, 3},
    '{0, 5, 32,   1, 0, 0},
    '{0, 7, 8,    3, 1, 0},
    '{1, 2, 20,   2, 0, 0},
    '{2, 0, 50,   2, 1, 2},
    '{3, 0, 1,    3, 0, 0},
    '{2, 0, 0,    3, 1, 0},
    '{3, 0, 1024, 1, 0, 0}
  };

  logic clk = 0, rst = 1, in_valid = 0;
  logic [LANES-1:0] a_i = '0, a_q = '0, b_i = '0, b_q = '0;
  logic [CNT_W-1:0] int_len = '0;
  logic dump_valid;
  logic [NLAGS*ACC_W-1:0] dump_re, dump_im;

  lagcorr_xf #(.LANES(LANES), .NLAGS(NLAGS), .MAX_INT_WORDS(MAXW)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .a_i(a_i), .a_q(a_q),
    .b_i(b_i), .b_q(b_q), .int_len(int_len),
    .dump_valid(dump_valid), .dump_re(dump_re), .dump_im(dump_im)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit sa_i [MAXS], sa_q [MAXS], sb_i [MAXS], sb_q [MAXS];
  int cur_mode, cur_dly, cur_leff, cur_nd, dcount, last_re0;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sg(bit b); return b ? 1 : -1; endfunction
  function automatic bit bgi(int m); return (m < 0) ? 1'b0 : sb_i[m]; endfunction
  function automatic bit bgq(int m); return (m < 0) ? 1'b0 : sb_q[m]; endfunction

  function automatic int lag_re(int k, int d);
    int s = 0;
    for (int n = d*cur_leff*LANES; n < (d+1)*cur_leff*LANES; n++)
      s += sg(sa_i[n])*sg(bgi(n-k)) + sg(sa_q[n])*sg(bgq(n-k));
    return s;
  endfunction

  function automatic int lag_im(int k, int d);
    int s = 0;
    for (int n = d*cur_leff*LANES; n < (d+1)*cur_leff*LANES; n++)
      s += sg(sa_q[n])*sg(bgi(n-k)) - sg(sa_i[n])*sg(bgq(n-k));
    return s;
  endfunction

  function automatic int slice(logic [NLAGS*ACC_W-1:0] v, int k);
    return int'($signed(v[k*ACC_W +: ACC_W]));
  endfunction

  task automatic observe();
    if (dump_valid) begin
      if (dcount < cur_nd) begin
        for (int k = 0; k < NLAGS; k++) begin
          // R1 R2 R3 R7: every lag against the sample model
          chk(slice(dump_re, k) == lag_re(k, dcount), "R3 lag real", slice(dump_re, k), lag_re(k, dcount));
          chk(slice(dump_im, k) == lag_im(k, dcount), "R2 lag imag", slice(dump_im, k), lag_im(k, dcount));
        end
        if (cur_mode == 0)
          chk(slice(dump_re, cur_dly) == 2*LANES*cur_leff, "R8 copy peak", slice(dump_re, cur_dly), 2*LANES*cur_leff);
        if (cur_mode == 1)
          chk(slice(dump_im, cur_dly) == 2*LANES*cur_leff, "R8 rotated peak", slice(dump_im, cur_dly), 2*LANES*cur_leff);
        if (cur_mode == 3 && cur_leff == MAXW)
          chk(slice(dump_re, 0) == 2*LANES*MAXW, "R7 full scale", slice(dump_re, 0), 2*LANES*MAXW);
        last_re0 = slice(dump_re, 0);
      end
      dcount++;
    end
  endtask

  task automatic drive_word(int w);
    in_valid = 1'b1;
    for (int i = 0; i < LANES; i++) begin
      a_i[i] = sa_i[w*LANES+i]; a_q[i] = sa_q[w*LANES+i];
      b_i[i] = sb_i[w*LANES+i]; b_q[i] = sb_q[w*LANES+i];
    end
  endtask

  task automatic run_scen(scen_t s);
    int nw, w;
    cur_mode = s.mode; cur_dly = s.dly; cur_nd = s.nd;
    cur_leff = (s.len < 1) ? 1 : s.len;
    nw = cur_leff * s.nd;
    for (int n = 0; n < nw*LANES; n++) begin
      sb_i[n] = 1'($urandom); sb_q[n] = 1'($urandom);
    end
    for (int n = 0; n < nw*LANES; n++) begin
      case (s.mode)
        0: begin sa_i[n] = bgi(n - s.dly); sa_q[n] = bgq(n - s.dly); end
        1: begin sa_i[n] = ~bgq(n - s.dly); sa_q[n] = bgi(n - s.dly); end
        2: begin sa_i[n] = 1'($urandom); sa_q[n] = 1'($urandom); end
        default: begin sa_i[n] = 1; sa_q[n] = 1; sb_i[n] = 1; sb_q[n] = 1; end
      endcase
    end
    // partial integration fed before reset must be discarded (R6)
    int_len = CNT_W'(s.len);
    for (int p = 0; p < s.pre; p++) begin
      @(negedge clk);
      in_valid = 1'b1;
      a_i = LANES'($urandom); a_q = LANES'($urandom);
      b_i = LANES'($urandom); b_q = LANES'($urandom);
    end
    @(negedge clk); rst = 1'b1; in_valid = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    chk(dump_valid == 1'b0, "R6 reset flag", int'(dump_valid), 0);
    chk(dump_re == '0 && dump_im == '0, "R6 reset readout", slice(dump_re, 0), 0);
    dcount = 0; w = 0;
    while (w < nw) begin
      @(negedge clk);
      observe();
      if (s.gap != 0 && ($urandom % 3) == 0) begin
        // idle word with junk data: ignored (R4)
        in_valid = 1'b0;
        a_i = LANES'($urandom); a_q = LANES'($urandom);
        b_i = LANES'($urandom); b_q = LANES'($urandom);
      end else begin
        drive_word(w);
        w++;
      end
    end
    @(negedge clk); observe(); in_valid = 1'b0;
    repeat (3) begin @(negedge clk); observe(); end
    chk(dcount == s.nd, "R4 dump count", dcount, s.nd);
    chk(slice(dump_re, 0) == last_re0, "R5 readout held", slice(dump_re, 0), last_re0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(dump_valid == 1'b0, "R6 initial flag", int'(dump_valid), 0);
    chk(dump_re == '0, "R6 initial readout", slice(dump_re, 0), 0);
    for (int s = 0; s < NSCEN; s++) run_scen(SCEN[s]);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule